// File: doc/BRIEF.md
# Accumulator strand steering unit

This unit sits at the dispatch stage of a machine whose instructions each work on one accumulator and one general register. It groups the instruction stream into strands, where a strand is the chain of work on a single accumulator, and sends each strand to one of a pool of processing elements. Because the element is picked when the strand opens, the architectural accumulators are renamed onto elements dynamically. The same accumulator can land on a different element each time it is reopened.

A strand opens with an instruction that writes its accumulator without reading it. The unit allocates the lowest-numbered free element and records the mapping. Any other instruction on that accumulator follows the mapping to the same element. An instruction carrying the kill mark drops the mapping once it has been dispatched. An element returns to the free pool only when its completion notification arrives. Opening a strand when no element is free raises a stall, and the instruction must be held at the input. An instruction that needs a mapping that does not exist raises an error and is not dispatched.

All outputs are combinational from the current instruction and the registered state. The map and the free pool update on the next clock edge.

Top module: `strand_steer`

## Requirements
- R1: After reset every element is free and no accumulator is mapped. When inst_valid_i is 0, disp_valid_o, stall_o and err_o are 0 and no state changes.
- R2: An opening instruction (acc_wr_i=1, acc_rd_i=0) is dispatched in the same cycle to the lowest-index free element, when one exists. From the next cycle that element is busy and the accumulator is mapped to it.
- R3: Any other valid instruction (acc_rd_i=1, or acc_wr_i=0) on a mapped accumulator is dispatched to the element it is mapped to. This covers reads, read-writes and kill-only instructions.
- R4: A dispatched instruction with acc_kill_i=1 removes the mapping from the next cycle. This applies to an opening instruction too, which makes a one-instruction strand. The element stays busy.
- R5: An opening instruction that finds every element busy sets stall_o=1 and disp_valid_o=0 and changes no state.
- R6: A bit of pe_free_i marks that element free from the next cycle, not in the same cycle. A free bit for an element that is not busy has no effect.
- R7: An opening instruction on an already mapped accumulator allocates a new element and remaps the accumulator. The old element stays busy until its free bit arrives.
- R8: A non-opening instruction on an unmapped accumulator sets err_o=1, disp_valid_o=0 and stall_o=0, and changes no state.
- R9: An element that is busy is never allocated. disp_pe_o is 0 whenever disp_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inst_valid_i | input | 1 | Decoded instruction present |
| acc_id_i | input | 3 | Architectural accumulator of the instruction |
| acc_rd_i | input | 1 | Instruction reads the accumulator |
| acc_wr_i | input | 1 | Instruction writes the accumulator |
| acc_kill_i | input | 1 | Instruction ends the strand |
| pe_free_i | input | 8 | Per-element completion notification, one bit per element |
| disp_valid_o | output | 1 | Instruction dispatched this cycle |
| disp_pe_o | output | 3 | Index of the target element |
| stall_o | output | 1 | Opening instruction blocked by a full pool |
| err_o | output | 1 | Instruction needs a missing mapping |

## Verification
A directed phase first opens a strand on every accumulator to fill the pool. It then shows that reads and read-writes follow the mapping, which separates map lookup from fresh allocation. Further cases exercise a stall held over a same-cycle free notification, which separates next-cycle from same-cycle reuse, and a reopen of a mapped accumulator, which shows that the old element is held. They also cover kill on an opening and on a following instruction, two simultaneous frees, which check the lowest-index choice, and a kill-only instruction. A random phase then mixes all instruction kinds with sparse and spurious free bits, so that allocation is tried against many busy patterns. A behavioural model compares every output on every cycle.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef struct packed {
    logic open_s;   // write without read: new strand
    logic follow;   // anything else: uses map
    logic kill;
  } ssu_op_t;
endpackage

// File: rtl/ssu_decode.sv
module ssu_decode
  import ssu_pkg::*;
(
  input  logic    valid_i,
  input  logic    rd_i,
  input  logic    wr_i,
  input  logic    kill_i,
  output ssu_op_t op_o
);
  always_comb begin
    op_o.open_s = valid_i & wr_i & ~rd_i;
    op_o.follow = valid_i & ~(wr_i & ~rd_i);
    op_o.kill   = valid_i & kill_i;
  end
endmodule

// File: rtl/ssu_free_list.sv
module ssu_free_list #(
  parameter int NUM_PE = 8,
  localparam int PE_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [NUM_PE-1:0] free_i,
  output logic              grant_vld_o,
  output logic [PE_W-1:0]   grant_idx_o,
  output logic [NUM_PE-1:0] busy_o
);
  logic [NUM_PE-1:0] busy_q;
  logic [NUM_PE-1:0] take_oh;

  // lowest free index wins
  always_comb begin
    grant_vld_o = 1'b0;
    grant_idx_o = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        grant_vld_o = 1'b1;
        grant_idx_o = PE_W'(i);
      end
    end
  end

  always_comb begin
    take_oh = '0;
    if (take_i && grant_vld_o) take_oh[grant_idx_o] = 1'b1;
  end

  // allocation wins over a notification for the same element
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~free_i) | take_oh;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ssu_acc_map.sv
module ssu_acc_map #(
  parameter int NUM_ACC = 8,
  parameter int NUM_PE  = 8,
  localparam int ACC_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   acc_i,
  output logic               live_o,
  output logic [PE_W-1:0]    pe_o,
  input  logic               set_i,
  input  logic               set_live_i,
  input  logic [PE_W-1:0]    set_pe_i,
  input  logic               drop_i,
  output logic [NUM_ACC-1:0] live_vec_o
);
  logic [NUM_ACC-1:0] live_q;
  logic [PE_W-1:0]    pe_q [NUM_ACC];

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_ent
    logic hit;
    assign hit = (acc_i == ACC_W'(a));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[a] <= 1'b0;
        pe_q[a]   <= '0;
      end else if (hit && set_i) begin
        live_q[a] <= set_live_i;
        pe_q[a]   <= set_pe_i;
      end else if (hit && drop_i) begin
        live_q[a] <= 1'b0;
      end
    end
  end

  assign live_o     = live_q[acc_i];
  assign pe_o       = pe_q[acc_i];
  assign live_vec_o = live_q;
endmodule

// File: rtl/strand_steer.sv
module strand_steer
  import ssu_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int NUM_ACC = 8,
  localparam int ACC_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_valid_i,
  input  logic [ACC_W-1:0]  acc_id_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic              acc_kill_i,
  input  logic [NUM_PE-1:0] pe_free_i,
  output logic              disp_valid_o,
  output logic [PE_W-1:0]   disp_pe_o,
  output logic              stall_o,
  output logic              err_o
);
  ssu_op_t            op;
  logic               grant_vld;
  logic [PE_W-1:0]    grant_idx;
  logic [NUM_PE-1:0]  pe_busy;
  logic               map_live;
  logic [PE_W-1:0]    map_pe;
  logic [NUM_ACC-1:0] acc_live;
  logic               open_go, follow_go;

  ssu_decode u_dec (
    .valid_i (inst_valid_i),
    .rd_i    (acc_rd_i),
    .wr_i    (acc_wr_i),
    .kill_i  (acc_kill_i),
    .op_o    (op)
  );

  ssu_free_list #(.NUM_PE(NUM_PE)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (op.open_s),
    .free_i      (pe_free_i),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx),
    .busy_o      (pe_busy)
  );

  assign open_go   = op.open_s & grant_vld;
  assign follow_go = op.follow & map_live;

  ssu_acc_map #(.NUM_ACC(NUM_ACC), .NUM_PE(NUM_PE)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc_id_i),
    .live_o     (map_live),
    .pe_o       (map_pe),
    .set_i      (open_go),
    .set_live_i (~op.kill),
    .set_pe_i   (grant_idx),
    .drop_i     (follow_go & op.kill),
    .live_vec_o (acc_live)
  );

  always_comb begin
    disp_valid_o = open_go | follow_go;
    disp_pe_o    = '0;
    if (open_go)        disp_pe_o = grant_idx;
    else if (follow_go) disp_pe_o = map_pe;
    stall_o = op.open_s & ~grant_vld;
    err_o   = op.follow & ~map_live;
  end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int NUM_PE  = 8,
  parameter int NUM_ACC = 8,
  localparam int ACC_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               inst_valid_i,
  input logic [ACC_W-1:0]   acc_id_i,
  input logic               acc_rd_i,
  input logic               acc_wr_i,
  input logic               acc_kill_i,
  input logic [NUM_PE-1:0]  pe_free_i,
  input logic               disp_valid_o,
  input logic [PE_W-1:0]    disp_pe_o,
  input logic               stall_o,
  input logic               err_o,
  input logic [NUM_PE-1:0]  busy_i,
  input logic [NUM_ACC-1:0] live_i
);
  logic opening;
  assign opening = inst_valid_i & acc_wr_i & ~acc_rd_i;

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_valid_i |-> !disp_valid_o && !stall_o && !err_o);

  assert_open_marks_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opening && disp_valid_o |=> busy_i[$past(disp_pe_o)]);

  assert_kill_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_valid_i && acc_kill_i && disp_valid_o |=> !live_i[$past(acc_id_i)]);

  assert_stall_only_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (&busy_i) && !disp_valid_o);

  assert_err_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !disp_valid_o && !stall_o);

  assert_no_busy_alloc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opening && disp_valid_o |-> !busy_i[disp_pe_o]);

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    assert_free_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pe_free_i[k] && !(opening && disp_valid_o && disp_pe_o == PE_W'(k)) |=> !busy_i[k]);
  end
endmodule

bind strand_steer ssu_checker #(.NUM_PE(NUM_PE), .NUM_ACC(NUM_ACC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inst_valid_i (inst_valid_i),
  .acc_id_i     (acc_id_i),
  .acc_rd_i     (acc_rd_i),
  .acc_wr_i     (acc_wr_i),
  .acc_kill_i   (acc_kill_i),
  .pe_free_i    (pe_free_i),
  .disp_valid_o (disp_valid_o),
  .disp_pe_o    (disp_pe_o),
  .stall_o      (stall_o),
  .err_o        (err_o),
  .busy_i       (pe_busy),
  .live_i       (acc_live)
);

// File: tb/strand_steer_bench.sv
`timescale 1ns/1ps
module strand_steer_bench;
  localparam int NPE  = 8;
  localparam int NACC = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       inst_valid_i = 1'b0;
  logic [2:0] acc_id_i = '0;
  logic       acc_rd_i = 1'b0, acc_wr_i = 1'b0, acc_kill_i = 1'b0;
  logic [7:0] pe_free_i = '0;
  logic       disp_valid_o;
  logic [2:0] disp_pe_o;
  logic       stall_o, err_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference state
  bit m_busy [NPE];
  bit m_live [NACC];
  int m_pe   [NACC];

  always #2.5 clk_i = ~clk_i;

  strand_steer u_strand_steer (.*);

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int acc, bit rd, bit wr, bit kill, logic [7:0] fr, string tag);
    bit e_dv, e_st, e_er;
    int e_pe;
    @(negedge clk_i);
    inst_valid_i = v; acc_id_i = 3'(acc);
    acc_rd_i = rd; acc_wr_i = wr; acc_kill_i = kill; pe_free_i = fr;
    #1;
    e_dv = 0; e_st = 0; e_er = 0; e_pe = 0;
    if (v && wr && !rd) begin
      e_pe = -1;
      for (int i = NPE - 1; i >= 0; i--) if (!m_busy[i]) e_pe = i;
      if (e_pe < 0) begin e_st = 1; e_pe = 0; end
      else e_dv = 1;
    end else if (v) begin
      if (m_live[acc]) begin e_dv = 1; e_pe = m_pe[acc]; end
      else e_er = 1;
    end
    check(tag, "disp_valid", int'(disp_valid_o), int'(e_dv));
    check(tag, "disp_pe", int'(disp_pe_o), e_pe);
    check(tag, "stall", int'(stall_o), int'(e_st));
    check(tag, "err", int'(err_o), int'(e_er));
    // state update for the coming edge
    for (int i = 0; i < NPE; i++) if (fr[i]) m_busy[i] = 0;
    if (e_dv && wr && !rd) begin
      m_busy[e_pe] = 1;
      m_live[acc] = !kill;
      m_pe[acc] = e_pe;
    end else if (e_dv && kill) begin
      m_live[acc] = 0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPE; i++) m_busy[i] = 0;
    for (int a = 0; a < NACC; a++) begin m_live[a] = 0; m_pe[a] = 0; end
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // R1: idle and empty map after reset
    step(0, 0, 1, 1, 1, 8'h00, "R1");
    step(1, 2, 1, 0, 0, 8'h00, "R1");      // unmapped read
    // R2: fill pool, lowest free each time
    for (int a = 0; a < NACC; a++) step(1, a, 0, 1, 0, 8'h00, "R2");
    // R3: reads and read-writes follow map
    step(1, 3, 1, 0, 0, 8'h00, "R3");
    step(1, 5, 1, 1, 0, 8'h00, "R3");
    // R5: full pool stalls, state held
    step(1, 0, 0, 1, 0, 8'h00, "R5");
    step(1, 0, 0, 1, 0, 8'h00, "R5");
    // R6: free in same cycle does not help; next cycle does
    step(1, 0, 0, 1, 0, 8'h10, "R6");
    step(1, 0, 0, 1, 0, 8'h00, "R6");      // gets element 4, remaps acc0
    // R7: acc0 now on element 4, element 0 still busy
    step(1, 0, 1, 0, 0, 8'h00, "R7");
    step(1, 7, 0, 1, 0, 8'h00, "R7");      // full again -> stall
    // R4: kill on follow
    step(1, 3, 1, 0, 1, 8'h00, "R4");
    step(1, 3, 1, 0, 0, 8'h00, "R4");      // now unmapped -> err
    step(1, 3, 0, 1, 0, 8'h00, "R4");      // element 3 still busy -> stall
    // R6: two frees, lowest wins next cycle; spurious free ignored later
    step(0, 0, 0, 0, 0, 8'h09, "R6");
    step(1, 3, 0, 1, 0, 8'h00, "R6");      // element 0
    // R4: one-instruction strand
    step(1, 6, 0, 1, 1, 8'h00, "R4");      // element 3, unmapped after
    step(1, 6, 1, 0, 0, 8'h00, "R4");
    // R3: kill-only instruction uses map
    step(1, 1, 0, 0, 1, 8'h00, "R3");
    step(1, 1, 1, 0, 0, 8'h00, "R8");
    // R6: free for an idle element has no effect
    step(0, 0, 0, 0, 0, 8'hFF, "R6");
    step(0, 0, 0, 0, 0, 8'h01, "R6");
    step(1, 2, 0, 1, 0, 8'h00, "R6");
    // R9: random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [7:0] fr;
      k  = int'($urandom_range(0, 9));
      fr = (($urandom_range(0, 3)) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      step(k != 0, int'($urandom_range(0, 7)), k >= 5, (k % 2) == 1,
           $urandom_range(0, 3) == 0, fr, "R9");
    end
    step(0, 0, 0, 0, 0, 8'h00, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule